// File: doc/BRIEF.md
# Qualified Pixel Capture

This block takes 8-bit pixel bytes from a CMOS image sensor and turns the qualified ones into a byte stream. It runs on the pixel clock that the sensor supplies. A byte is kept only while both the frame qualifier and the line qualifier are high. During blanking the sensor drives a filler byte of 0x10, and that filler never reaches the stream. The data and both qualifiers pass through an input register before any decision is made on them. Every output is driven from a register.

Each output byte comes with a valid strobe. The first byte of a line is marked with a start flag and the last byte with an end flag. Each byte also carries the index of its line inside the current frame. The index returns to 0 when the frame qualifier rises. A single-cycle frame-done pulse follows every fall of the frame qualifier.

The sensor may already be partway through a line when capture is enabled. In that case the block waits for the line qualifier to drop and starts on the next rising edge of the qualifiers. Turning capture off takes effect only at a line boundary, so every line on the stream is complete. Line bracketing codes that the sensor sends inside the active window (FF 00 00 80 at the start, FF 00 00 9D at the end) are ordinary data and pass through unchanged.

Top module: `pix_capture`

## Requirements
- R1: While reset is asserted and just after it is released, `px_valid_o`, `sol_o`, `eol_o` and `frame_done_o` are 0, and `px_data_o` and `line_o` are 0.
- R2: A byte on `pix_i` that is sampled on rising edge k with `fval_i` and `lval_i` both high appears unchanged on `px_data_o`, with `px_valid_o` high, in the cycle after rising edge k+2. This includes the bracketing bytes FF 00 00 80 and FF 00 00 9D.
- R3: No byte sampled while `fval_i` or `lval_i` is low is output, and the filler 0x10 driven during blanking never appears on the stream.
- R4: `sol_o` is high together with the first byte of each captured line and `eol_o` together with its last byte. A one-byte line carries both flags. After an `eol_o` byte, `px_valid_o` is low for at least one cycle.
- R5: Capture of a line begins only on a low-to-high transition of the registered `lval_i` while `fval_i` is high. If `cap_en_i` is raised in the middle of a line, that line is skipped and the next full line is captured.
- R6: If `cap_en_i` is lowered in the middle of a captured line, the line is still output in full, and no later line is captured while `cap_en_i` stays low.
- R7: `line_o` is 0 for the first captured line after `fval_i` rises and goes up by one for each later captured line. It stays constant across the bytes of a line.
- R8: `frame_done_o` is a one-cycle pulse in the cycle after rising edge k+1, where rising edge k is the first to sample `fval_i` low after it was high. It is produced whatever the state of `cap_en_i`.
- R9: The bytes of a captured line come out on consecutive cycles with no gap between its first and its last byte.
- R10: `lval_i` that is high while `fval_i` is low is ignored. This holds even if `fval_i` then rises while `lval_i` is still high; such a line is not captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock from the sensor |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_en_i | input | 1 | Capture enable |
| fval_i | input | 1 | Frame qualifier from the sensor |
| lval_i | input | 1 | Line qualifier from the sensor |
| pix_i | input | DATA_W (8) | Sensor pixel data |
| px_data_o | output | DATA_W (8) | Captured byte |
| px_valid_o | output | 1 | Captured byte is valid |
| sol_o | output | 1 | First byte of a line |
| eol_o | output | 1 | Last byte of a line |
| line_o | output | LINE_W (12) | Index of the byte's line in the frame |
| frame_done_o | output | 1 | Pulse after the frame qualifier falls |

## Verification
Full frames of several long lines carrying the bracketing codes, with filler bytes in the blanking, show that every qualified byte arrives exactly two edges later and that nothing else does. The same frames show the line index restarting in a second frame. Lines of one, two and three bytes separate the start and end flags when they land on the same byte or on adjacent bytes. Raising the enable mid-line, and a line qualifier that is already high when the frame qualifier rises, show the wait for a clean line edge. Dropping the enable mid-line shows that a started line finishes and that the following line is dropped.

// File: rtl/pcap_pkg.sv
package pcap_pkg;
    typedef enum logic [1:0] {
        ST_OFF,
        ST_WAIT_QUIET,
        ST_READY,
        ST_LINE
    } cap_state_e;
endpackage

// File: rtl/pcap_in_stage.sv
// Input register stage: registers the sensor qualifiers and data, and keeps
// one more copy of each qualifier for edge detection.
module pcap_in_stage #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fval_i,
    input  logic              lval_i,
    input  logic [DATA_W-1:0] pix_i,
    output logic              fv_o,
    output logic              lv_o,
    output logic              fv_prev_o,
    output logic              lv_prev_o,
    output logic [DATA_W-1:0] dat_o
);
    typedef struct packed {
        logic              fv;
        logic              lv;
        logic              fv_prev;
        logic              lv_prev;
        logic [DATA_W-1:0] dat;
    } in_regs_t;

    in_regs_t in_d, in_q;

    always_comb begin
        in_d         = in_q;
        in_d.fv      = fval_i;
        in_d.lv      = lval_i;
        in_d.fv_prev = in_q.fv;
        in_d.lv_prev = in_q.lv;
        in_d.dat     = pix_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) in_q <= '0;
        else        in_q <= in_d;
    end

    assign fv_o      = in_q.fv;
    assign lv_o      = in_q.lv;
    assign fv_prev_o = in_q.fv_prev;
    assign lv_prev_o = in_q.lv_prev;
    assign dat_o     = in_q.dat;
endmodule

// File: rtl/pcap_line_track.sv
// Line index per frame and frame-done pulse.
module pcap_line_track #(
    parameter int LINE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fv_i,
    input  logic              fv_prev_i,
    input  logic              eol_emit_i,
    output logic [LINE_W-1:0] line_cnt_o,
    output logic              frame_done_o
);
    typedef struct packed {
        logic [LINE_W-1:0] cnt;
        logic              done;
    } trk_regs_t;

    trk_regs_t trk_d, trk_q;
    logic frame_start;
    logic frame_end;

    assign frame_start = fv_i && !fv_prev_i;
    assign frame_end   = !fv_i && fv_prev_i;

    always_comb begin
        trk_d      = trk_q;
        trk_d.done = frame_end;
        if (frame_start)     trk_d.cnt = '0;
        else if (eol_emit_i) trk_d.cnt = trk_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    assign line_cnt_o   = trk_q.cnt;
    assign frame_done_o = trk_q.done;

    // R8: the frame-done pulse never lasts more than one cycle
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        trk_q.done |=> !trk_q.done);
endmodule

// File: rtl/pcap_seq.sv
// Capture sequencer: waits for a clean line start, holds one byte back so the
// last byte of a line can be flagged, and registers the output stream.
module pcap_seq
    import pcap_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int LINE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en_i,
    input  logic              fv_i,
    input  logic              lv_i,
    input  logic              lv_prev_i,
    input  logic [DATA_W-1:0] dat_i,
    input  logic [LINE_W-1:0] line_cnt_i,
    output logic [DATA_W-1:0] px_data_o,
    output logic              px_valid_o,
    output logic              sol_o,
    output logic              eol_o,
    output logic [LINE_W-1:0] line_o,
    output logic              eol_emit_o
);
    typedef struct packed {
        cap_state_e        st;
        logic [DATA_W-1:0] pend_dat;
        logic              pend_sol;
        logic [DATA_W-1:0] out_dat;
        logic              out_vld;
        logic              out_sol;
        logic              out_eol;
        logic [LINE_W-1:0] out_line;
    } seq_regs_t;

    seq_regs_t seq_d, seq_q;
    logic qual_both;

    assign qual_both = fv_i && lv_i;

    always_comb begin
        seq_d         = seq_q;
        seq_d.out_vld = 1'b0;
        seq_d.out_sol = 1'b0;
        seq_d.out_eol = 1'b0;
        case (seq_q.st)
            ST_OFF: begin
                if (cap_en_i) seq_d.st = ST_WAIT_QUIET;
            end
            ST_WAIT_QUIET: begin
                if (!cap_en_i) seq_d.st = ST_OFF;
                else if (!lv_i) seq_d.st = ST_READY;
            end
            ST_READY: begin
                if (!cap_en_i) begin
                    seq_d.st = ST_OFF;
                end else if (qual_both && !lv_prev_i) begin
                    seq_d.st       = ST_LINE;
                    seq_d.pend_dat = dat_i;
                    seq_d.pend_sol = 1'b1;
                end
            end
            ST_LINE: begin
                seq_d.out_vld  = 1'b1;
                seq_d.out_dat  = seq_q.pend_dat;
                seq_d.out_sol  = seq_q.pend_sol;
                seq_d.out_line = line_cnt_i;
                if (qual_both) begin
                    seq_d.pend_dat = dat_i;
                    seq_d.pend_sol = 1'b0;
                end else begin
                    seq_d.out_eol = 1'b1;
                    seq_d.st      = cap_en_i ? ST_READY : ST_OFF;
                end
            end
            default: seq_d.st = ST_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign px_data_o  = seq_q.out_dat;
    assign px_valid_o = seq_q.out_vld;
    assign sol_o      = seq_q.out_sol;
    assign eol_o      = seq_q.out_eol;
    assign line_o     = seq_q.out_line;
    assign eol_emit_o = seq_d.out_eol;

    // R9: inside a line, a byte that is not the last is followed by another
    a_r9_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.out_vld && !seq_q.out_eol) |=> seq_q.out_vld);

    // R4: the stream is idle for at least one cycle after a line's last byte
    a_r4_gap_after_eol: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.out_eol |=> !seq_q.out_vld);
endmodule

// File: rtl/pix_capture.sv
module pix_capture #(
    parameter int DATA_W = 8,
    parameter int LINE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en_i,
    input  logic              fval_i,
    input  logic              lval_i,
    input  logic [DATA_W-1:0] pix_i,
    output logic [DATA_W-1:0] px_data_o,
    output logic              px_valid_o,
    output logic              sol_o,
    output logic              eol_o,
    output logic [LINE_W-1:0] line_o,
    output logic              frame_done_o
);
    logic              fv_r, lv_r, fv_prev_r, lv_prev_r;
    logic [DATA_W-1:0] dat_r;
    logic [LINE_W-1:0] line_cnt;
    logic              eol_emit;

    pcap_in_stage #(.DATA_W(DATA_W)) u_in (
        .clk       (clk),
        .rst_n     (rst_n),
        .fval_i    (fval_i),
        .lval_i    (lval_i),
        .pix_i     (pix_i),
        .fv_o      (fv_r),
        .lv_o      (lv_r),
        .fv_prev_o (fv_prev_r),
        .lv_prev_o (lv_prev_r),
        .dat_o     (dat_r)
    );

    pcap_seq #(.DATA_W(DATA_W), .LINE_W(LINE_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_en_i   (cap_en_i),
        .fv_i       (fv_r),
        .lv_i       (lv_r),
        .lv_prev_i  (lv_prev_r),
        .dat_i      (dat_r),
        .line_cnt_i (line_cnt),
        .px_data_o  (px_data_o),
        .px_valid_o (px_valid_o),
        .sol_o      (sol_o),
        .eol_o      (eol_o),
        .line_o     (line_o),
        .eol_emit_o (eol_emit)
    );

    pcap_line_track #(.LINE_W(LINE_W)) u_trk (
        .clk          (clk),
        .rst_n        (rst_n),
        .fv_i         (fv_r),
        .fv_prev_i    (fv_prev_r),
        .eol_emit_i   (eol_emit),
        .line_cnt_o   (line_cnt),
        .frame_done_o (frame_done_o)
    );

    // R3: every output byte was sampled with both qualifiers high
    a_r3_valid_needs_quals: assert property (@(posedge clk) disable iff (!rst_n)
        px_valid_o |-> $past(fval_i && lval_i, 3));

    // R5: a line's first byte was preceded by a low line qualifier
    a_r5_sol_after_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (px_valid_o && sol_o) |-> !$past(lval_i, 4));

    // R7: the line index does not change inside a line
    a_r7_line_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (px_valid_o && !sol_o) |-> $stable(line_o));

    // R4: line flags only ride on valid bytes
    a_r4_flags_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (sol_o || eol_o) |-> px_valid_o);
endmodule

// File: tb/pix_capture_bench.sv
module pix_capture_bench;
    localparam int CLK_PERIOD = 10;
    localparam int MAXL = 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cap_en = 1'b0;
    logic        fval = 1'b0;
    logic        lval = 1'b0;
    logic [7:0]  pix = 8'h10;
    logic [7:0]  px_data;
    logic        px_valid, sol, eol, frame_done;
    logic [11:0] line_idx;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit prev_fv = 1'b0;

    logic [7:0] lg_dat [MAXL];
    bit         lg_sol [MAXL];
    bit         lg_eol [MAXL];
    int         lg_line[MAXL];
    int         lg_cyc [MAXL];
    int         n_lg = 0;
    logic [7:0] ex_dat [MAXL];
    bit         ex_sol [MAXL];
    bit         ex_eol [MAXL];
    int         ex_line[MAXL];
    int         ex_cyc [MAXL];
    int         n_ex = 0;
    int         lg_fd[64];
    int         n_lgfd = 0;
    int         ex_fd[64];
    int         n_exfd = 0;

    pix_capture u_pix_capture (
        .clk          (clk),
        .rst_n        (rst_n),
        .cap_en_i     (cap_en),
        .fval_i       (fval),
        .lval_i       (lval),
        .pix_i        (pix),
        .px_data_o    (px_data),
        .px_valid_o   (px_valid),
        .sol_o        (sol),
        .eol_o        (eol),
        .line_o       (line_idx),
        .frame_done_o (frame_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (px_valid && n_lg < MAXL) begin
                lg_dat[n_lg] = px_data; lg_sol[n_lg] = sol; lg_eol[n_lg] = eol;
                lg_line[n_lg] = int'(line_idx); lg_cyc[n_lg] = cyc;
                n_lg++;
            end
            if (frame_done && n_lgfd < 64) begin
                lg_fd[n_lgfd] = cyc; n_lgfd++;
            end
        end
    end

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    function automatic logic [7:0] byte_at(int n, int i, int base);
        if (n >= 8) begin
            if (i == 0 || i == n-4) return 8'hFF;
            if (i == 1 || i == 2 || i == n-3 || i == n-2) return 8'h00;
            if (i == 3) return 8'h80;
            if (i == n-1) return 8'h9D;
        end
        return 8'(base + i);
    endfunction

    // one sensor cycle; frame-done expected when the frame qualifier falls (R8)
    task automatic drive(bit f, bit l, logic [7:0] d);
        @(negedge clk);
        if (prev_fv && !f) begin ex_fd[n_exfd] = cyc + 2; n_exfd++; end
        prev_fv = f;
        fval = f; lval = l; pix = d;
    endtask

    task automatic idle(int n, bit f, bit l);
        for (int i = 0; i < n; i++) drive(f, l, 8'h10);
    endtask

    task automatic pix_line(int n, int base, bit expect_cap, int idx, int en_at, bit en_val);
        for (int i = 0; i < n; i++) begin
            drive(1'b1, 1'b1, byte_at(n, i, base));
            if (i == en_at) cap_en = en_val;
            if (expect_cap) begin
                ex_dat[n_ex] = byte_at(n, i, base); ex_sol[n_ex] = (i == 0);
                ex_eol[n_ex] = (i == n-1); ex_line[n_ex] = idx; ex_cyc[n_ex] = cyc + 3;
                n_ex++;
            end
        end
    endtask

    task automatic compare_logs(string req);
        check(n_lg == n_ex, req, "byte count", n_lg, n_ex);
        for (int i = 0; i < n_ex && i < n_lg; i++) begin
            check(lg_dat[i] == ex_dat[i] && lg_sol[i] == ex_sol[i] && lg_eol[i] == ex_eol[i]
                  && lg_line[i] == ex_line[i] && lg_cyc[i] == ex_cyc[i],
                  req, $sformatf("byte %0d (sol%0d eol%0d line%0d cyc%0d)", i,
                                 lg_sol[i], lg_eol[i], lg_line[i], lg_cyc[i]),
                  int'(lg_dat[i]), int'(ex_dat[i]));
        end
        for (int i = 0; i < n_lg; i++)
            check(lg_dat[i] != 8'h10, "R3", "filler on stream", int'(lg_dat[i]), 0);
        check(n_lgfd == n_exfd, "R8", "frame-done count", n_lgfd, n_exfd);
        for (int i = 0; i < n_exfd && i < n_lgfd; i++)
            check(lg_fd[i] == ex_fd[i], "R8", "frame-done cycle", lg_fd[i], ex_fd[i]);
        n_lg = 0; n_ex = 0; n_lgfd = 0; n_exfd = 0;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check(!px_valid && !sol && !eol && !frame_done, "R1", "flags in reset",
              {px_valid, sol, eol, frame_done}, 0);
        check(px_data == 8'h00 && line_idx == 12'd0, "R1", "data/line in reset",
              int'(px_data), 0);
        rst_n = 1'b1;
        idle(2, 1'b0, 1'b0);
        @(negedge clk);
        check(!px_valid && !sol && !eol && !frame_done, "R1", "flags after reset",
              {px_valid, sol, eol, frame_done}, 0);
        compare_logs("R1");
    endtask

    // R2 R3 R4 R7 R10: two frames of long lines with bracketing codes
    task automatic t_full_frames();
        cap_en = 1'b1;
        idle(4, 1'b0, 1'b0);
        idle(3, 1'b0, 1'b1);      // R10: line qualifier without frame
        idle(2, 1'b0, 1'b0);
        idle(2, 1'b1, 1'b0);
        pix_line(12, 8'h40, 1'b1, 0, -1, 1'b1);
        idle(3, 1'b1, 1'b0);
        pix_line(10, 8'h60, 1'b1, 1, -1, 1'b1);
        idle(3, 1'b1, 1'b0);
        pix_line(9, 8'h20, 1'b1, 2, -1, 1'b1);
        idle(2, 1'b1, 1'b0);
        idle(4, 1'b0, 1'b0);
        idle(2, 1'b1, 1'b0);
        pix_line(8, 8'hA0, 1'b1, 0, -1, 1'b1);   // R7: index restarts
        idle(2, 1'b1, 1'b0);
        idle(5, 1'b0, 1'b0);
        compare_logs("R2");
    endtask

    // R4: one-, two- and three-byte lines
    task automatic t_short_lines();
        idle(2, 1'b1, 1'b0);
        pix_line(1, 8'h31, 1'b1, 0, -1, 1'b1);
        idle(2, 1'b1, 1'b0);
        pix_line(2, 8'h41, 1'b1, 1, -1, 1'b1);
        idle(2, 1'b1, 1'b0);
        pix_line(3, 8'h51, 1'b1, 2, -1, 1'b1);
        idle(2, 1'b1, 1'b0);
        idle(5, 1'b0, 1'b0);
        compare_logs("R4");
    endtask

    // R5 R10: enable raised mid-line; frame rising under an active line
    task automatic t_enable_midline();
        cap_en = 1'b0;
        idle(3, 1'b0, 1'b0);
        idle(2, 1'b1, 1'b0);
        pix_line(10, 8'h70, 1'b0, 0, 4, 1'b1);
        idle(3, 1'b1, 1'b0);
        pix_line(8, 8'h90, 1'b1, 0, -1, 1'b1);
        idle(2, 1'b1, 1'b0);
        idle(3, 1'b0, 1'b0);
        idle(2, 1'b0, 1'b1);
        for (int i = 0; i < 4; i++) drive(1'b1, 1'b1, 8'(8'hC0 + i));
        idle(3, 1'b1, 1'b0);
        pix_line(6, 8'hD0, 1'b1, 0, -1, 1'b1);
        idle(2, 1'b1, 1'b0);
        idle(5, 1'b0, 1'b0);
        compare_logs("R5");
    endtask

    // R6: enable dropped mid-line
    task automatic t_disable_midline();
        idle(2, 1'b1, 1'b0);
        pix_line(10, 8'h21, 1'b1, 0, 3, 1'b0);
        idle(3, 1'b1, 1'b0);
        pix_line(8, 8'h51, 1'b0, 0, -1, 1'b0);
        idle(2, 1'b1, 1'b0);
        idle(5, 1'b0, 1'b0);
        compare_logs("R6");
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        t_reset();
        t_full_frames();
        t_short_lines();
        t_enable_midline();
        t_disable_midline();
        summary();
        $finish;
    end
endmodule